// File: doc/BRIEF.md
# Failed-Word Replacement Store

This block sits beside a memory controller and stands in for memory words that have failed. It holds a small set of spare entries. Each entry has a physical word address tag, an enable flag and one data word wide enough for a 32-bit word plus its 7 check bits. On every access, the mapped physical address is compared with all enabled tags at once. When it matches one, the access goes to the spare entry instead of the main array. A read returns the spare word. A write updates the spare word; the main array may also be written, but its copy of that address is never used again.

When the error-correction logic repairs a single-bit error, it presents the address and the corrected word on the capture port. The block then stores them in the lowest free entry. If the address already has an entry, that entry is refreshed instead. Matching is purely combinational, so the hit flag and the substituted read data appear in the same cycle as the address, and no access latency is added. A full flag reports that every entry is in use. A sticky overflow flag records that a capture was dropped for lack of space.

Top module: `healer_array`

## Requirements
- R1: After reset no entry is enabled: `hit` stays 0 for every address (including address 0), and `full` and `overflow` are 0.
- R2: While `acc_valid` is 1 and `acc_addr` equals the tag of an enabled entry, `hit` is 1 and `rdata` carries that entry's word in the same cycle. With no hit, `rdata` is all zeros.
- R3: A capture (`heal_valid` = 1) of an address with no enabled entry enables one free entry, holding that address and `heal_data`. `full` is 1 exactly when all ENTRIES entries are enabled (32 by default).
- R4: A capture of an address that already has an enabled entry replaces that entry's word. It consumes no further entry, so no address is ever held twice.
- R5: A capture of a new address while `full` is 1 is dropped: that address still misses afterwards. `overflow` becomes 1 from the next cycle and stays 1 until reset. A capture of an already-held address while full still updates its word.
- R6: A write (`acc_valid` = 1, `acc_we` = 1) that hits replaces the entry's word with `acc_wdata` from the next cycle. A write that misses changes no entry.
- R7: When a capture and a write hit target the same entry in the same cycle, the captured word is kept.
- R8: A captured entry is visible from the cycle after the capture edge. An access in the capture cycle itself sees the state before the capture.
- R9: While `acc_valid` is 0, `hit` is 0 and `rdata` is zero whatever `acc_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (24) | Mapped physical word address of the access |
| acc_wdata | input | DATA_W (39) | Word to write |
| hit | output | 1 | Access address is held by an enabled entry |
| rdata | output | DATA_W (39) | Substituted word on a hit, zero otherwise |
| heal_valid | input | 1 | Capture a repaired word this cycle |
| heal_addr | input | ADDR_W (24) | Physical address of the failed word |
| heal_data | input | DATA_W (39) | Corrected word |
| full | output | 1 | All entries are enabled |
| overflow | output | 1 | Sticky: a capture was dropped while full |

## Verification
The bench targets the boundaries of the store:
- The 31st, 32nd and 33rd distinct capture. A design with an off-by-one count raises `full` early or late, or keeps one address too many.
- Re-capturing a held address just below capacity. A design that allocates duplicates fills up one capture early.
- A capture and a write hit to the same address in one cycle. Wrong priority leaves the stale write data in place.
- An access in the same cycle as the capture of its address. A design that bypasses the capture wrongly reports a hit.
- A write that misses, and accesses with `acc_valid` low. Both would expose a store that updates or matches when it should stay silent.

// File: rtl/healer_pkg.sv
package healer_pkg;

  typedef enum logic [1:0] {
    HEAL_IDLE   = 2'd0,
    HEAL_UPDATE = 2'd1,
    HEAL_ALLOC  = 2'd2,
    HEAL_DROP   = 2'd3
  } heal_act_e;

  // Decide what a capture request does, given whether its address is
  // already held and whether any entry is still free.
  function automatic heal_act_e heal_decide(input logic req,
                                            input logic held,
                                            input logic has_free);
    heal_act_e act;
    if (!req)          act = HEAL_IDLE;
    else if (held)     act = HEAL_UPDATE;
    else if (has_free) act = HEAL_ALLOC;
    else               act = HEAL_DROP;
    return act;
  endfunction

  // True when the selected word must be driven out.
  function automatic logic access_hits(input logic valid, input logic any_match);
    return valid & any_match;
  endfunction

endpackage

// File: rtl/healer_match.sv
module healer_match #(
  parameter int N  = 32,
  parameter int AW = 24,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [N-1:0]         en,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         match_vec,
  output logic                 any,
  output logic [IW-1:0]        idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = en[g] && (tags[g] == key);
  end

  assign any = |match_vec;

  // Tags are unique, so the match vector is one-hot and an OR-encoder suffices.
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/healer_alloc.sv
module healer_alloc #(
  parameter int N = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  en,
  output logic [N-1:0]  free_onehot,
  output logic [IW-1:0] free_idx,
  output logic          has_free,
  output logic          all_used
);

  always_comb begin
    free_onehot = '0;
    free_idx    = '0;
    has_free    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!en[i] && !has_free) begin
        free_onehot[i] = 1'b1;
        free_idx       = IW'(i);
        has_free       = 1'b1;
      end
    end
  end

  assign all_used = &en;

endmodule

// File: rtl/healer_store.sv
module healer_store #(
  parameter int N  = 32,
  parameter int AW = 24,
  parameter int DW = 39,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tag_we,
  input  logic [IW-1:0]        tag_idx,
  input  logic [AW-1:0]        tag_addr,
  input  logic                 cap_we,
  input  logic [IW-1:0]        cap_idx,
  input  logic [DW-1:0]        cap_data,
  input  logic                 wr_we,
  input  logic [IW-1:0]        wr_idx,
  input  logic [DW-1:0]        wr_data,
  output logic [N-1:0][AW-1:0] tags,
  output logic [N-1:0]         en,
  output logic [N-1:0][DW-1:0] words
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam logic [IW-1:0] SLOT = IW'(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          en[g] <= 1'b0;
      else if (tag_we && tag_idx == SLOT)  en[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (tag_we && tag_idx == SLOT) tags[g] <= tag_addr;
    end

    // Capture port has priority over an access write to the same slot.
    always_ff @(posedge clk) begin
      if (cap_we && cap_idx == SLOT)     words[g] <= cap_data;
      else if (wr_we && wr_idx == SLOT)  words[g] <= wr_data;
    end
  end

endmodule

// File: rtl/healer_array.sv
module healer_array
  import healer_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata,
  input  logic              heal_valid,
  input  logic [ADDR_W-1:0] heal_addr,
  input  logic [DATA_W-1:0] heal_data,
  output logic              full,
  output logic              overflow
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][ADDR_W-1:0] tags;
  logic [ENTRIES-1:0]             en_vec;
  logic [ENTRIES-1:0][DATA_W-1:0] words;

  logic [ENTRIES-1:0] acc_match_vec, heal_match_vec, alloc_onehot;
  logic               acc_any, heal_any, has_free, all_used;
  logic [IW-1:0]      acc_idx, heal_idx, alloc_idx;

  heal_act_e          heal_act;
  logic               write_hit, cap_we, tag_we, drop_evt;
  logic [IW-1:0]      cap_idx;

  healer_match #(.N(ENTRIES), .AW(ADDR_W)) u_acc_match (
    .tags(tags), .en(en_vec), .key(acc_addr),
    .match_vec(acc_match_vec), .any(acc_any), .idx(acc_idx)
  );

  healer_match #(.N(ENTRIES), .AW(ADDR_W)) u_heal_match (
    .tags(tags), .en(en_vec), .key(heal_addr),
    .match_vec(heal_match_vec), .any(heal_any), .idx(heal_idx)
  );

  healer_alloc #(.N(ENTRIES)) u_alloc (
    .en(en_vec), .free_onehot(alloc_onehot), .free_idx(alloc_idx),
    .has_free(has_free), .all_used(all_used)
  );

  assign heal_act  = heal_decide(heal_valid, heal_any, has_free);
  assign tag_we    = (heal_act == HEAL_ALLOC);
  assign cap_we    = (heal_act == HEAL_ALLOC) || (heal_act == HEAL_UPDATE);
  assign cap_idx   = (heal_act == HEAL_UPDATE) ? heal_idx : alloc_idx;
  assign drop_evt  = (heal_act == HEAL_DROP);
  assign hit       = access_hits(acc_valid, acc_any);
  assign write_hit = hit && acc_we;

  healer_store #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .tag_we(tag_we), .tag_idx(alloc_idx), .tag_addr(heal_addr),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(heal_data),
    .wr_we(write_hit), .wr_idx(acc_idx), .wr_data(acc_wdata),
    .tags(tags), .en(en_vec), .words(words)
  );

  assign rdata = hit ? words[acc_idx] : '0;
  assign full  = all_used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overflow <= 1'b0;
    else if (drop_evt) overflow <= 1'b1;
  end

endmodule

// File: rtl/healer_array_chk.sv
module healer_array_chk #(
  parameter int N  = 32,
  parameter int AW = 24,
  parameter int DW = 39
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_we,
  input logic [AW-1:0] acc_addr,
  input logic [DW-1:0] acc_wdata,
  input logic          hit,
  input logic [DW-1:0] rdata,
  input logic          heal_valid,
  input logic [AW-1:0] heal_addr,
  input logic [DW-1:0] heal_data,
  input logic          full,
  input logic          overflow,
  input logic [N-1:0]  acc_match_vec,
  input logic [N-1:0]  heal_match_vec
);

  a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!hit && rdata == '0));

  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == '0);

  a_r4_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_match_vec) && $onehot0(heal_match_vec));

  a_r3_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (heal_valid && full && heal_match_vec == '0) |=> overflow);

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_capture_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (heal_valid && !(full && heal_match_vec == '0)) ##1
      (acc_valid && acc_addr == $past(heal_addr))
    |-> (hit && rdata == $past(heal_data)));

  a_r6_write_hit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && hit && !heal_valid) ##1
      (acc_valid && acc_addr == $past(acc_addr))
    |-> (hit && rdata == $past(acc_wdata)));

endmodule

bind healer_array healer_array_chk #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .hit(hit), .rdata(rdata),
  .heal_valid(heal_valid), .heal_addr(heal_addr), .heal_data(heal_data),
  .full(full), .overflow(overflow),
  .acc_match_vec(acc_match_vec), .heal_match_vec(heal_match_vec)
);

// File: tb/healer_array_test.sv
module healer_array_test;

  localparam int AW = 24;
  localparam int DW = 39;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic          hit;
  logic [DW-1:0] rdata;
  logic          heal_valid = 1'b0;
  logic [AW-1:0] heal_addr = '0;
  logic [DW-1:0] heal_data = '0;
  logic          full, overflow;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  healer_array uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .hit(hit), .rdata(rdata),
    .heal_valid(heal_valid), .heal_addr(heal_addr), .heal_data(heal_data),
    .full(full), .overflow(overflow)
  );

  // op: 0 capture, 1 read, 2 write
  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          exp_hit;
    logic [DW-1:0] exp_rd;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 24'h000100, 39'h11_1111_1111, 1'b0, 39'h0,          4'd3}, // R3
    '{2'd1, 24'h000100, 39'h0,            1'b1, 39'h11_1111_1111, 4'd8}, // R8
    '{2'd1, 24'h000101, 39'h0,            1'b0, 39'h0,          4'd2}, // R2
    '{2'd0, 24'h123456, 39'h22_2222_2222, 1'b0, 39'h0,          4'd3}, // R3
    '{2'd1, 24'h123456, 39'h0,            1'b1, 39'h22_2222_2222, 4'd2}, // R2
    '{2'd2, 24'h123456, 39'h33_3333_3333, 1'b1, 39'h22_2222_2222, 4'd6}, // R6
    '{2'd1, 24'h123456, 39'h0,            1'b1, 39'h33_3333_3333, 4'd6}, // R6
    '{2'd1, 24'h000100, 39'h0,            1'b1, 39'h11_1111_1111, 4'd6}, // R6
    '{2'd2, 24'h777777, 39'h44_4444_4444, 1'b0, 39'h0,          4'd6}, // R6
    '{2'd1, 24'h777777, 39'h0,            1'b0, 39'h0,          4'd6}, // R6
    '{2'd0, 24'h000100, 39'h55_5555_5555, 1'b0, 39'h0,          4'd4}, // R4
    '{2'd1, 24'h000100, 39'h0,            1'b1, 39'h55_5555_5555, 4'd4}  // R4
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic capture(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    acc_valid = 1'b0; heal_valid = 1'b1; heal_addr = a; heal_data = d;
    @(negedge clk);
    heal_valid = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] a, output logic h, output logic [DW-1:0] d);
    @(negedge clk);
    heal_valid = 1'b0; acc_valid = 1'b1; acc_we = 1'b0; acc_addr = a;
    #1;
    h = hit; d = rdata;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_valid = 1'b0; heal_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired before completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic h;
    logic [DW-1:0] d;
    do_reset();

    // R1: reset state
    #1;
    chk("R1", "full", 64'(full), 64'd0);
    chk("R1", "overflow", 64'(overflow), 64'd0);
    probe(24'h000000, h, d);
    chk("R1", "hit addr0", 64'(h), 64'd0);

    // Table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      acc_we = 1'b0; heal_valid = 1'b0; acc_valid = 1'b0;
      case (VECS[i].op)
        2'd0: begin heal_valid = 1'b1; heal_addr = VECS[i].addr; heal_data = VECS[i].data; end
        2'd1: begin acc_valid = 1'b1; acc_addr = VECS[i].addr; end
        default: begin acc_valid = 1'b1; acc_we = 1'b1; acc_addr = VECS[i].addr;
                       acc_wdata = VECS[i].data; end
      endcase
      #1;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d hit", i), 64'(hit), 64'(VECS[i].exp_hit));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d rdata", i), 64'(rdata), 64'(VECS[i].exp_rd));
    end
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0; heal_valid = 1'b0;

    // R9: address held but access not valid
    acc_addr = 24'h000100; #1;
    chk("R9", "hit idle", 64'(hit), 64'd0);
    chk("R9", "rdata idle", 64'(rdata), 64'd0);

    // R8: access in the capture cycle sees the old state
    @(negedge clk);
    heal_valid = 1'b1; heal_addr = 24'h00ABCD; heal_data = 39'h66_6666_6666;
    acc_valid = 1'b1; acc_we = 1'b0; acc_addr = 24'h00ABCD;
    #1;
    chk("R8", "same-cycle hit", 64'(hit), 64'd0);
    @(negedge clk);
    heal_valid = 1'b0; #1;
    chk("R8", "next-cycle hit", 64'(hit), 64'd1);
    chk("R8", "next-cycle rdata", 64'(rdata), 64'h66_6666_6666);

    // R7: capture and write hit to one entry in one cycle
    @(negedge clk);
    heal_valid = 1'b1; heal_addr = 24'h000100; heal_data = 39'h07_0707_0707;
    acc_valid = 1'b1; acc_we = 1'b1; acc_addr = 24'h000100; acc_wdata = 39'h7F_0000_0001;
    @(negedge clk);
    heal_valid = 1'b0; acc_we = 1'b0; acc_valid = 1'b0;
    probe(24'h000100, h, d);
    chk("R7", "capture wins", 64'(d), 64'h07_0707_0707);

    // R3: fill to 31 entries (3 held so far)
    for (int i = 0; i < 28; i++) capture(24'h400000 + 24'(i), 39'(i) + 39'h100);
    #1;
    chk("R3", "full at 31", 64'(full), 64'd0);
    // R4: duplicate capture does not consume an entry
    capture(24'h400000, 39'h0A_BCDE_F012);
    #1;
    chk("R4", "full after dup", 64'(full), 64'd0);
    probe(24'h400000, h, d);
    chk("R4", "dup data", 64'(d), 64'h0A_BCDE_F012);
    capture(24'h500000, 39'h50);
    #1;
    chk("R3", "full at 32", 64'(full), 64'd1);
    chk("R5", "no overflow yet", 64'(overflow), 64'd0);

    // R5: 33rd distinct capture is dropped
    capture(24'h600000, 39'h60);
    #1;
    chk("R5", "overflow set", 64'(overflow), 64'd1);
    probe(24'h600000, h, d);
    chk("R5", "dropped misses", 64'(h), 64'd0);
    capture(24'h400005, 39'h5A5A5);
    probe(24'h400005, h, d);
    chk("R5", "update while full", 64'(d), 64'h5A5A5);
    chk("R5", "overflow sticky", 64'(overflow), 64'd1);
    chk("R3", "still full", 64'(full), 64'd1);

    // R1: reset clears everything
    do_reset();
    #1;
    chk("R1", "full after reset", 64'(full), 64'd0);
    chk("R1", "overflow after reset", 64'(overflow), 64'd0);
    probe(24'h000100, h, d);
    chk("R1", "entry cleared", 64'(h), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule